// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Read Slave (Event Driven)

This block models the slave side of a two-wire serial EEPROM holding 256 bytes. The host does not clock a real bus. It writes clock and data levels into a register, and each write appears at the block as a one-cycle event carrying the new SCL and SDA levels. The slave compares each event with the line levels it latched last time. From that comparison it finds start and stop conditions and rising clock edges, and it samples data bits on those edges.

After a start, the slave shifts in an 8-bit control byte and acknowledges it. It then shifts in an 8-bit word address, acknowledges that, and fetches the addressed byte into its data register. When the control byte's least significant bit requests a read, each address-phase rising edge drives the most significant bit of the data register onto SDA. The data register then shifts left by one. The byte returned in a transaction is therefore the one fetched at the end of the previous transaction. The storage is filled through a separate preload port before use.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: After reset, sda_o is 1 and busy is 0. The latched line is taken as idle: SCL and SDA both high.
- R2: An event with SCL high both before and now, and SDA falling from 1 to 0, is a start. It sets the bit position to the first control bit, clears the control byte and sets busy.
- R3: When no transfer is in progress, every event other than a start leaves busy at 0 and the block in the same state. sda_o then shows the SDA level of that event.
- R4: A bit is taken only on an SCL rise where SDA equals the latched level. If SDA changes on the same rise, the bit is dropped and the bit position does not advance.
- R5: The 9th rising edge after a start, counting only accepted bits, is an acknowledge: sda_o reads 0 whatever the host drove.
- R6: If control bit 0 (the last one received) is 1, the 8 address-phase rising edges drive sda_o with the data register's bits, MSB first.
- R7: If control bit 0 is 0, address-phase rising edges show the host's SDA level on sda_o.
- R8: After the 8th address bit the slave fetches storage[address] into the data register. The next rising edge is an acknowledge (sda_o 0), and busy is 0 after it. Later bits are ignored until a start.
- R9: A stop (SCL high both before and now, SDA rising) does not reset the bit position. A rise with stable SDA that precedes it still counts as a bit.
- R10: A start in the middle of a control byte restarts the count, so the acknowledge comes exactly 8 accepted bits later.
- R11: Any event with SCL low latches that event's SDA level onto sda_o.
- R12: A preload write stores the given byte at the given address. A later transaction naming that address followed by a read transaction returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One-cycle pulse: the host wrote new line levels |
| ev_scl | input | 1 | SCL level of the event |
| ev_sda | input | 1 | SDA level driven by the host in the event |
| pre_we | input | 1 | Preload write strobe for the storage |
| pre_addr | input | ADDR_W (8) | Preload address |
| pre_data | input | DATA_W (8) | Preload byte |
| sda_o | output | 1 | SDA level latched by the slave after the last event |
| busy | output | 1 | High while a transfer, a pending acknowledge or a fetch is in progress |

## Verification
The assertions assume the following about the inputs:
- Preload writes happen only while busy is low, so a fetch never reads a cell in the cycle it is written.
- ev_scl and ev_sda hold known values whenever ev_valid is high.
- Reset is asserted on the first clock edge.

The stimulus pulses ev_valid for a single cycle and leaves an idle cycle after every event. It loads the whole storage before the first start and changes a cell again only between transactions, after busy has fallen. Start, stop and bit sequences are built from SCL-low, SCL-rise and SCL-fall events, as a host register driver would issue them.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Classification of one host line-write event
  typedef enum logic [2:0] {
    EV_NONE,   // no event this cycle
    EV_START,  // SCL high throughout, SDA fell
    EV_STOP,   // SCL high throughout, SDA rose
    EV_IDLE,   // no transfer active: event ignored
    EV_ACK,    // SCL rise while an acknowledge is pending
    EV_BIT,    // SCL rise with stable SDA: accepted bit
    EV_SKEW,   // SCL rise with SDA changing: bit dropped
    EV_HOLD    // any other edge or level write
  } ev_kind_t;

endpackage

// File: rtl/eep_line_decode.sv
module eep_line_decode
  import eep_pkg::*;
(
  input  logic     ev_valid,
  input  logic     scl_i,
  input  logic     sda_i,
  input  logic     scl_q,
  input  logic     sda_q,
  input  logic     tick_zero,
  input  logic     ack_pend,
  output ev_kind_t kind
);

  logic scl_high_held;
  logic scl_rise;

  assign scl_high_held = scl_q && scl_i;
  assign scl_rise      = !scl_q && scl_i;

  always_comb begin
    kind = EV_NONE;
    if (ev_valid) begin
      if (scl_high_held && (sda_q != sda_i)) begin
        kind = sda_i ? EV_STOP : EV_START;
      end else if (tick_zero && !ack_pend) begin
        kind = EV_IDLE;
      end else if (scl_rise) begin
        if (ack_pend)              kind = EV_ACK;
        else if (sda_q == sda_i)   kind = EV_BIT;
        else                       kind = EV_SKEW;
      end else begin
        kind = EV_HOLD;
      end
    end
  end

endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TICK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_kind_t          kind,
  input  logic              sda_i,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr_q,
  output logic [TICK_W-1:0] tick_q,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              ack_q,
  output logic              data_msb,
  output logic              ovr_en,
  output logic              ovr_val,
  output logic              busy_n
);

  localparam int CMD_END  = CMD_W + 1;
  localparam int ADDR_END = CMD_END + ADDR_W;
  localparam logic [TICK_W-1:0] T_ONE  = TICK_W'(1);
  localparam logic [TICK_W-1:0] T_CMD  = TICK_W'(CMD_END);
  localparam logic [TICK_W-1:0] T_ADDR = TICK_W'(ADDR_END);

  logic [DATA_W-1:0] data_q, data_n;
  logic [TICK_W-1:0] tick_n;
  logic [CMD_W-1:0]  cmd_n;
  logic [ADDR_W-1:0] addr_n;
  logic              ack_n;
  logic              fetch_q, fetch_n;
  logic              load_q;

  always_comb begin
    tick_n  = tick_q;
    cmd_n   = cmd_q;
    addr_n  = addr_q;
    data_n  = data_q;
    ack_n   = ack_q;
    fetch_n = 1'b0;
    ovr_en  = 1'b0;
    ovr_val = 1'b0;
    if (load_q) data_n = rd_data;
    unique case (kind)
      EV_START: begin
        tick_n = T_ONE;
        cmd_n  = '0;
      end
      EV_ACK: begin
        ovr_en = 1'b1;
        ack_n  = 1'b0;
      end
      EV_BIT: begin
        if (tick_q < T_CMD) begin
          cmd_n  = {cmd_q[CMD_W-2:0], sda_i};
          tick_n = tick_q + T_ONE;
          if (tick_n == T_CMD) ack_n = 1'b1;
        end else if (tick_q < T_ADDR) begin
          if (cmd_q[0]) begin
            ovr_en  = 1'b1;
            ovr_val = data_q[DATA_W-1];
          end
          addr_n = {addr_q[ADDR_W-2:0], sda_i};
          data_n = data_q << 1;
          tick_n = tick_q + T_ONE;
          if (tick_n == T_ADDR) begin
            fetch_n = 1'b1;
            ack_n   = 1'b1;
            tick_n  = '0;
          end
        end else begin
          ovr_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      ack_q   <= 1'b0;
      fetch_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      tick_q  <= tick_n;
      cmd_q   <= cmd_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      ack_q   <= ack_n;
      fetch_q <= fetch_n;
      load_q  <= fetch_q;
    end
  end

  assign rd_en    = fetch_q;
  assign data_msb = data_q[DATA_W-1];
  assign busy_n   = (tick_n != '0) || ack_n || fetch_n || fetch_q;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
  import eep_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_scl,
  input  logic              ev_sda,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic              sda_o,
  output logic              busy
);

  localparam int TICK_W = $clog2(CMD_W + ADDR_W + 2);

  logic              scl_q;
  logic              sda_q;
  logic              busy_q;
  ev_kind_t          kind;
  logic [TICK_W-1:0] tick_w;
  logic [CMD_W-1:0]  cmd_w;
  logic              ack_w;
  logic              data_msb_w;
  logic              ovr_en;
  logic              ovr_val;
  logic              busy_n;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  eep_line_decode u_decode (
    .ev_valid  (ev_valid),
    .scl_i     (ev_scl),
    .sda_i     (ev_sda),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .tick_zero (tick_w == '0),
    .ack_pend  (ack_w),
    .kind      (kind)
  );

  eep_seq #(
    .CMD_W  (CMD_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TICK_W (TICK_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .sda_i    (ev_sda),
    .rd_data  (rd_data),
    .rd_en    (rd_en),
    .addr_q   (rd_addr),
    .tick_q   (tick_w),
    .cmd_q    (cmd_w),
    .ack_q    (ack_w),
    .data_msb (data_msb_w),
    .ovr_en   (ovr_en),
    .ovr_val  (ovr_val),
    .busy_n   (busy_n)
  );

  eep_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // Latched line: slave overrides SDA on acknowledge and read bits
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      if (ev_valid) begin
        scl_q <= ev_scl;
        sda_q <= ovr_en ? ovr_val : ev_sda;
      end
    end
  end

  assign sda_o = sda_q;
  assign busy  = busy_q;

endmodule

// File: rtl/twowire_eeprom_chk.sv
module twowire_eeprom_chk #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int TICK_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              ev_scl,
  input logic              ev_sda,
  input logic              scl_q,
  input logic              sda_q,
  input logic [TICK_W-1:0] tick_w,
  input logic [CMD_W-1:0]  cmd_w,
  input logic              ack_w,
  input logic              data_msb_w,
  input logic              sda_o,
  input logic              busy
);

  localparam logic [TICK_W-1:0] T_CMD  = TICK_W'(CMD_W + 1);
  localparam logic [TICK_W-1:0] T_ADDR = TICK_W'(CMD_W + 1 + ADDR_W);
  localparam logic [TICK_W-1:0] T_ONE  = TICK_W'(1);

  logic rise_ev;
  logic start_ev;
  assign rise_ev  = ev_valid && !scl_q && ev_scl;
  assign start_ev = ev_valid && scl_q && ev_scl && sda_q && !ev_sda;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (sda_o && !busy));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (tick_w == T_ONE && cmd_w == '0 && busy));

  a_r3_idle_ignored: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !busy && !start_ev) |=> (!busy && sda_o == $past(ev_sda)));

  a_r4_skew_dropped: assert property (@(posedge clk) disable iff (rst)
    (rise_ev && !ack_w && (sda_q != ev_sda)) |=> $stable(tick_w));

  a_r5_ack_low: assert property (@(posedge clk) disable iff (rst)
    (rise_ev && ack_w) |=> (!sda_o && !ack_w));

  a_r6_read_bit: assert property (@(posedge clk) disable iff (rst)
    (rise_ev && !ack_w && (sda_q == ev_sda) && cmd_w[0] &&
     tick_w >= T_CMD && tick_w < T_ADDR) |=> (sda_o == $past(data_msb_w)));

  a_r11_low_scl_latch: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_scl) |=> (sda_o == $past(ev_sda)));

endmodule

bind twowire_eeprom_slave twowire_eeprom_chk #(
  .CMD_W  (CMD_W),
  .ADDR_W (ADDR_W),
  .TICK_W (TICK_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ev_valid   (ev_valid),
  .ev_scl     (ev_scl),
  .ev_sda     (ev_sda),
  .scl_q      (scl_q),
  .sda_q      (sda_q),
  .tick_w     (tick_w),
  .cmd_w      (cmd_w),
  .ack_w      (ack_w),
  .data_msb_w (data_msb_w),
  .sda_o      (sda_o),
  .busy       (busy)
);

// File: tb/twowire_eeprom_slave_tb_top.sv
module twowire_eeprom_slave_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic       ev_scl = 1'b1;
  logic       ev_sda = 1'b1;
  logic       pre_we = 1'b0;
  logic [7:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic       sda_o;
  logic       busy;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] shadow [256];
  logic [7:0] held = 8'h00;   // expected data register at start of address phase

  always #10 clk = ~clk;      // 50 MHz

  twowire_eeprom_slave dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_scl(ev_scl), .ev_sda(ev_sda),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .sda_o(sda_o), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ev(input logic s, input logic d);
    @(negedge clk);
    ev_valid = 1'b1; ev_scl = s; ev_sda = d;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic bit_clk(input logic b, output logic seen);
    ev(1'b0, b); ev(1'b1, b); seen = sda_o; ev(1'b0, b);
  endtask

  task automatic start_cond;
    ev(1'b0, 1'b1); ev(1'b1, 1'b1); ev(1'b1, 1'b0); ev(1'b0, 1'b0);
  endtask

  task automatic stop_cond;
    ev(1'b0, 1'b0); ev(1'b1, 1'b0); ev(1'b1, 1'b1);
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d; shadow[a] = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // address phase, closing acknowledge and stop
  task automatic addr_phase(input logic rd, input logic [7:0] a);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(a[i], s);
      if (rd) chk("R6 read bit", s, held[i]);
      else    chk("R7 write-direction echo", s, a[i]);
    end
    chk("R8 busy in address phase", busy, 1);
    bit_clk(1'b1, s);
    chk("R8 address ack", s, 0);
    chk("R8 busy after ack", busy, 0);
    held = shadow[a];
    bit_clk(1'b0, s);
    chk("R8 ignored after ack", s, 0);
    bit_clk(1'b1, s);
    chk("R8 ignored after ack", {31'd0, s} | {31'd0, busy}, 1);
    stop_cond;
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] a);
    logic s;
    start_cond;
    chk("R2 busy after start", busy, 1);
    for (int i = 7; i >= 0; i--) begin
      bit_clk(cmd[i], s);
      chk("R4 control bit echo", s, cmd[i]);
    end
    bit_clk(1'b1, s);
    chk("R5 control ack", s, 0);
    addr_phase(cmd[0], a);
  endtask

  initial begin
    logic s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset sda", sda_o, 1);
    chk("R1 reset busy", busy, 0);

    // R12: fill storage
    for (int i = 0; i < 256; i++) preload(8'(i), 8'((i * 37 + 11) & 255));

    // R3: idle events are ignored; R11: low-SCL events latch SDA
    ev(1'b0, 1'b0);
    chk("R11 low scl latch", sda_o, 0);
    for (int i = 0; i < 9; i++) begin
      logic b;
      b = logic'((i * 5 + 1) % 3 == 0);
      bit_clk(b, s);
      chk("R3 idle echo", s, b);
      chk("R3 idle busy", busy, 0);
    end
    ev(1'b0, 1'b1);
    chk("R11 low scl latch", sda_o, 1);

    // R2 / R5 / R6 / R8: first read returns reset data register (0)
    xfer(8'hA1, 8'h10);

    // R4: skewed bit dropped
    start_cond;
    for (int i = 0; i < 7; i++) begin bit_clk(1'b1, s); chk("R4 bit", s, 1); end
    ev(1'b0, 1'b1); ev(1'b1, 1'b0);
    chk("R4 skew latch", sda_o, 0);
    ev(1'b0, 1'b0);
    bit_clk(1'b1, s);
    chk("R4 skew not counted", s, 1);
    bit_clk(1'b1, s);
    chk("R5 ack after 8 accepted", s, 0);
    addr_phase(1'b1, 8'h22);

    // R9: stop does not reset count (its rise counts as bit 5, value 0)
    start_cond;
    for (int i = 0; i < 4; i++) begin bit_clk(1'b1, s); chk("R9 bit", s, 1); end
    stop_cond;
    chk("R9 busy after stop", busy, 1);
    for (int i = 0; i < 3; i++) begin bit_clk(1'b1, s); chk("R9 remaining bit", s, 1); end
    bit_clk(1'b1, s);
    chk("R9 ack position", s, 0);
    addr_phase(1'b1, 8'h33);

    // R10: repeated start restarts count
    start_cond;
    for (int i = 0; i < 5; i++) bit_clk(1'b1, s);
    start_cond;
    for (int i = 0; i < 8; i++) begin bit_clk(1'b1, s); chk("R10 no early ack", s, 1); end
    bit_clk(1'b1, s);
    chk("R10 ack after restart", s, 0);
    addr_phase(1'b1, 8'h44);

    // R12: rewrite a cell between transactions and read it back
    preload(8'h3C, 8'h5A);
    xfer(8'hA0, 8'h3C);
    chk("R12 expected held", held, 8'h5A);
    xfer(8'hA1, 8'h00);

    // sweep every address, mixing read and write directions
    for (int k = 0; k < 256; k++) begin
      logic [7:0] a;
      logic [7:0] c;
      a = 8'((k * 97 + 5) & 255);
      c = {7'(k), logic'(k % 5 != 3)};
      xfer(c, a);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule